// File: doc/BRIEF.md
# Magic Divisor Constant Generator

This block turns an unsigned divisor into the three constants that an attribute address unit needs to divide a linear thread index by that divisor without a real divider: a right-shift amount, a multiplier whose top bit is always set, and a flag that selects the round-down variant of the multiply. The shift is fixed by the position of the divisor's leading one, so no search over exponents is needed. The block forms the power of two that sits 32 bits above that shift and divides it by the divisor with a bit-serial restoring divider. It then uses the remainder to choose between the rounded-up quotient and the round-down form.

A caller presents the divisor with a one-cycle start strobe while the block is idle. The block raises busy and, 2·DW+1 clock edges later, pulses done with the constants on its outputs. The constants stay there until the next accepted start. Power-of-two divisors are also marked on a separate output, so the caller may use a plain shift. A zero divisor is rejected at once with an error flag.

Top module: `magic_const_gen`

## Requirements
- R1: For a nonzero divisor d, `shift` equals floor(log2 d), that is, the bit index of the highest set bit of d.
- R2: Let N = 2^(shift+32), q = floor(N/d) and r = N mod d. When r ≤ 2^shift (including r = 0), `magic` equals ceil(N/d) − 1 taken modulo 2^32, and `round_down` is 1.
- R3: When r > 2^shift, `magic` equals ceil(N/d), and `round_down` is 0.
- R4: For every nonzero divisor, bit 31 of `magic` is 1 when done is high.
- R5: `pow2` is 1 exactly when d is a nonzero power of two. Such a divisor yields `magic` = 0xFFFFFFFF with `round_down` = 1.
- R6: A start with d = 0 while idle pulses `done` with `err` = 1 on the accepting edge. At that point `magic`, `shift`, `round_down` and `pow2` are all 0, and `busy` stays low.
- R7: A start with nonzero d while busy is low raises `busy` on the accepting edge. `done` is a one-cycle pulse on the 2·DW+1-th edge after the accepting edge (65 with DW = 32), and `busy` falls on that same edge. `err` is 0 with that result.
- R8: A start strobe while busy is high is ignored. The result that follows belongs to the divisor that was accepted.
- R9: All result outputs hold their values from the done pulse until the next accepted start.
- R10: For every 32-bit x, ((x·magic + round_down·magic) >> 32) >> shift equals floor(x/d), computed in 64-bit arithmetic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request, taken only while busy is low |
| divisor | input | DW (32) | Divisor d, sampled on the accepting edge |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| err | output | 1 | Last request had a zero divisor |
| pow2 | output | 1 | Last divisor was a power of two |
| round_down | output | 1 | Round-down multiply variant selected |
| shift | output | SW (5) | Post-multiply right shift |
| magic | output | DW (32) | Multiplier constant, top bit set |

## Verification
The assertions assume that start is a strobe the caller may raise at any time, and that the divisor only matters on the edge that accepts it. The bench therefore changes the divisor freely outside accepting edges and pulses start in the middle of a busy period. The properties tie the done, busy and error behaviour to the handshake alone and never to a divisor that is not held. The stimulus keeps divisors within the 32-bit range. Random divisors are right-shifted by a random amount so that every leading-one position is reached, and a zero divisor is sent only as a directed error case.

// File: rtl/magic_pkg.sv
package magic_pkg;

    localparam int unsigned DIV_W_DEFAULT = 32;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_t;

    typedef struct packed {
        logic err;
        logic pow2;
        logic round_down;
    } gen_flags_t;

    // Position of the highest set bit; returns 0 for a zero operand.
    function automatic int unsigned lead_one_pos(input logic [63:0] v, input int unsigned w);
        int unsigned p;
        p = 0;
        for (int unsigned i = 0; i < w; i++) begin
            if (v[i]) p = i;
        end
        return p;
    endfunction

endpackage

// File: rtl/magic_msb_find.sv
module magic_msb_find #(
    parameter int unsigned DW = magic_pkg::DIV_W_DEFAULT,
    localparam int unsigned SW = $clog2(DW)
) (
    input  logic [DW-1:0] value,
    output logic [SW-1:0] msb_pos,
    output logic          is_zero,
    output logic          is_pow2
);

    logic [DW-1:0] below_mask;
    logic [DW-1:0] hit;

    // One-hot of the leading one: bit i set when value[i] is set and nothing above it is.
    genvar g;
    generate
        for (g = 0; g < DW; g++) begin : g_hit
            if (g == DW - 1) begin : g_top
                assign below_mask[g] = 1'b0;
            end else begin : g_rest
                assign below_mask[g] = |value[DW-1:g+1];
            end
            assign hit[g] = value[g] & ~below_mask[g];
        end
    endgenerate

    always_comb begin
        msb_pos = '0;
        for (int i = 0; i < DW; i++) begin
            if (hit[i]) msb_pos = SW'(i);
        end
    end

    assign is_zero = (value == '0);
    assign is_pow2 = !is_zero && ((value & (value - DW'(1))) == '0);

endmodule

// File: rtl/magic_serial_div.sv
module magic_serial_div #(
    parameter int unsigned DW = magic_pkg::DIV_W_DEFAULT,
    localparam int unsigned NW = 2 * DW,
    localparam int unsigned CW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quot_lo,
    output logic [DW-1:0] remainder,
    output logic          valid
);

    logic [NW-1:0] dq_q;
    logic [DW-1:0] rem_q;
    logic [DW-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;

    logic [DW-1:0] trial_lo;
    logic          trial_hi;
    logic          take;
    logic [DW-1:0] rem_next;

    // Trial remainder is {rem, next dividend bit}; its top bit is rem_q[DW-1].
    assign trial_hi = rem_q[DW-1];
    assign trial_lo = {rem_q[DW-2:0], dq_q[NW-1]};
    assign take     = trial_hi || (trial_lo >= dvs_q);
    assign rem_next = take ? (trial_lo - dvs_q) : trial_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_q  <= '0;
            rem_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (load) begin
                dq_q  <= dividend;
                rem_q <= '0;
                dvs_q <= divisor;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_next;
                dq_q  <= {dq_q[NW-2:0], take};
                if (cnt_q == CW'(NW - 1)) begin
                    run_q <= 1'b0;
                    valid <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    assign quot_lo   = dq_q[DW-1:0];
    assign remainder = rem_q;

endmodule

// File: rtl/magic_pick.sv
module magic_pick #(
    parameter int unsigned DW = magic_pkg::DIV_W_DEFAULT,
    localparam int unsigned SW = $clog2(DW)
) (
    input  logic [DW-1:0] quot_lo,
    input  logic [DW-1:0] remainder,
    input  logic [SW-1:0] shift,
    output logic [DW-1:0] magic,
    output logic          round_down
);

    logic [DW-1:0] limit;
    logic          exact;

    assign limit = DW'(1) << shift;
    assign exact = (remainder == '0);

    // Exact case: the true quotient is 2^DW, so ceil-1 wraps to all ones.
    always_comb begin
        if (exact) begin
            magic      = quot_lo - DW'(1);
            round_down = 1'b1;
        end else if (remainder <= limit) begin
            magic      = quot_lo;
            round_down = 1'b1;
        end else begin
            magic      = quot_lo + DW'(1);
            round_down = 1'b0;
        end
    end

endmodule

// File: rtl/magic_const_gen.sv
module magic_const_gen
    import magic_pkg::*;
#(
    parameter int unsigned DW = DIV_W_DEFAULT,
    localparam int unsigned SW = $clog2(DW),
    localparam int unsigned NW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          pow2,
    output logic          round_down,
    output logic [SW-1:0] shift,
    output logic [DW-1:0] magic
);

    gen_state_t    state_q;
    gen_flags_t    flags_q;
    logic [SW-1:0] shift_q;
    logic [DW-1:0] magic_q;
    logic [SW-1:0] hold_shift_q;
    logic          hold_pow2_q;

    logic [SW-1:0] msb_pos;
    logic          d_zero;
    logic          d_pow2;
    logic          accept;
    logic          div_load;
    logic [NW-1:0] dividend;
    logic [DW-1:0] quot_lo;
    logic [DW-1:0] rem;
    logic          div_valid;
    logic [DW-1:0] pick_magic;
    logic          pick_rd;

    magic_msb_find #(.DW(DW)) u_msb (
        .value   (divisor),
        .msb_pos (msb_pos),
        .is_zero (d_zero),
        .is_pow2 (d_pow2)
    );

    assign accept   = (state_q == ST_IDLE) && start;
    assign div_load = accept && !d_zero;
    assign dividend = {{(NW-1){1'b0}}, 1'b1} << (int'(msb_pos) + DW);

    magic_serial_div #(.DW(DW)) u_div (
        .clk       (clk),
        .rst       (rst),
        .load      (div_load),
        .dividend  (dividend),
        .divisor   (divisor),
        .quot_lo   (quot_lo),
        .remainder (rem),
        .valid     (div_valid)
    );

    magic_pick #(.DW(DW)) u_pick (
        .quot_lo    (quot_lo),
        .remainder  (rem),
        .shift      (hold_shift_q),
        .magic      (pick_magic),
        .round_down (pick_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            flags_q      <= '0;
            shift_q      <= '0;
            magic_q      <= '0;
            hold_shift_q <= '0;
            hold_pow2_q  <= 1'b0;
            done         <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (d_zero) begin
                            flags_q <= '{err: 1'b1, pow2: 1'b0, round_down: 1'b0};
                            shift_q <= '0;
                            magic_q <= '0;
                            done    <= 1'b1;
                        end else begin
                            hold_shift_q <= msb_pos;
                            hold_pow2_q  <= d_pow2;
                            state_q      <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (div_valid) begin
                        flags_q <= '{err: 1'b0, pow2: hold_pow2_q, round_down: pick_rd};
                        shift_q <= hold_shift_q;
                        magic_q <= pick_magic;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q == ST_RUN);
    assign err        = flags_q.err;
    assign pow2       = flags_q.pow2;
    assign round_down = flags_q.round_down;
    assign shift      = shift_q;
    assign magic      = magic_q;

endmodule

// File: rtl/magic_const_chk.sv
module magic_const_chk #(
    parameter int unsigned DW = magic_pkg::DIV_W_DEFAULT,
    localparam int unsigned SW = $clog2(DW),
    localparam int unsigned LW = $clog2(2 * DW + 4) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [DW-1:0] divisor,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          pow2,
    input logic          round_down,
    input logic [SW-1:0] shift,
    input logic [DW-1:0] magic
);

    logic [LW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + LW'(1);
        else           run_len <= '0;
    end

    // R4
    magic_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> magic[DW-1]);

    // R5
    pow2_allones_chk: assert property (@(posedge clk) disable iff (rst)
        (done && pow2) |-> (round_down && (magic == '1)));

    // R6
    zero_err_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (divisor == '0)) |=> (done && err && !busy && magic == '0
                                                  && shift == '0 && !round_down && !pow2));

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (divisor != '0)) |=> busy);

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R7
    latency_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len <= LW'(2 * DW)));

    // R8
    busy_ends_in_done_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || (done && !err)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(magic) && $stable(shift) && $stable(round_down)
                               && $stable(pow2) && $stable(err)));

endmodule

bind magic_const_gen magic_const_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .divisor    (divisor),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .pow2       (pow2),
    .round_down (round_down),
    .shift      (shift),
    .magic      (magic)
);

// File: tb/tb_magic_const_gen.sv
`timescale 1ns/1ps
module tb_magic_const_gen;

    localparam int unsigned DW = 32;
    localparam int unsigned SW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] divisor = '0;
    logic          busy, done, err, pow2, round_down;
    logic [SW-1:0] shift;
    logic [DW-1:0] magic;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    magic_const_gen #(.DW(DW)) dut (
        .clk(clk), .rst(rst), .start(start), .divisor(divisor),
        .busy(busy), .done(done), .err(err), .pow2(pow2),
        .round_down(round_down), .shift(shift), .magic(magic)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int unsigned ref_shift(input logic [31:0] d);
        int unsigned p = 0;
        for (int i = 0; i < 32; i++) if (d[i]) p = i;
        return p;
    endfunction

    // Expected magic and flag from R2/R3.
    task automatic ref_const(input logic [31:0] d, output logic [31:0] m, output bit rd);
        logic [63:0] n, q, r, ceil_q;
        int unsigned s;
        s = ref_shift(d);
        n = 64'd1 << (s + 32);
        q = n / {32'd0, d};
        r = n % {32'd0, d};
        ceil_q = (r == 0) ? q : q + 64'd1;
        if (r <= (64'd1 << s)) begin
            m = 32'(ceil_q - 64'd1);
            rd = 1'b1;
        end else begin
            m = 32'(ceil_q);
            rd = 1'b0;
        end
    endtask

    function automatic logic [63:0] magic_divide(input logic [31:0] x, input logic [31:0] m,
                                                 input bit rd, input logic [4:0] s);
        logic [63:0] p;
        p = {32'd0, x} * {32'd0, m} + (rd ? {32'd0, m} : 64'd0);
        return (p >> 32) >> s;
    endfunction

    task automatic run_one(input logic [31:0] d, input bit poke_busy);
        int cyc;
        logic [31:0] m_exp;
        bit rd_exp;
        bit p2;
        logic [31:0] xs [8];
        @(negedge clk);
        start = 1'b1;
        divisor = d;
        @(negedge clk);
        start = 1'b0;
        divisor = $urandom();
        cyc = 1;
        while (!done && cyc < 200) begin
            if (poke_busy && cyc == 10) begin
                start = 1'b1;
                divisor = 32'd7;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (d == 0) begin
            check(cyc == 1 && done && err && !busy, "R6", "zero divisor done/err",
                  {62'd0, err, done}, 64'd3);
            check(magic == 0 && shift == 0 && !round_down && !pow2, "R6", "zero outputs",
                  {magic, 27'd0, shift}, 64'd0);
            return;
        end
        check(cyc == 2 * DW + 2 && !busy && !err, "R7", "done latency",
              64'(cyc - 1), 64'(2 * DW + 1));
        check(shift == 5'(ref_shift(d)), "R1", "shift", 64'(shift), 64'(ref_shift(d)));
        ref_const(d, m_exp, rd_exp);
        check(magic == m_exp && round_down == rd_exp, rd_exp ? "R2" : "R3", "magic/flag",
              {31'd0, round_down, magic}, {31'd0, rd_exp, m_exp});
        check(magic[31], "R4", "magic top bit", 64'(magic[31]), 64'd1);
        p2 = ((d & (d - 1)) == 0);
        check(pow2 == p2, "R5", "pow2 flag", 64'(pow2), 64'(p2));
        if (poke_busy)
            check(magic == m_exp, "R8", "start during busy ignored", 64'(magic), 64'(m_exp));
        xs[0] = 0; xs[1] = d - 1; xs[2] = d; xs[3] = 32'hFFFF_FFFF;
        for (int k = 4; k < 8; k++) xs[k] = $urandom();
        for (int k = 0; k < 8; k++)
            check(magic_divide(xs[k], magic, round_down, shift) == {32'd0, xs[k] / d}, "R10",
                  "magic divide", magic_divide(xs[k], magic, round_down, shift),
                  {32'd0, xs[k] / d});
        repeat (3) @(negedge clk);
        check(magic == m_exp && shift == 5'(ref_shift(d)) && !done, "R9", "outputs held",
              64'(magic), 64'(m_exp));
    endtask

    initial begin
        int wd = 0;
        while (!finished && wd < 190000) begin
            @(posedge clk);
            wd++;
        end
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=finish", wd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] dir [15];
        void'($urandom(32'd20240611));
        dir = '{32'd1, 32'd2, 32'd3, 32'd5, 32'd7, 32'd9, 32'd10, 32'd70, 32'd641,
                32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF, 32'd6, 32'h0001_0000, 32'd1000003};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !err && !pow2 && !round_down && shift == 0 && magic == 0,
              "R7", "reset state", {magic, 27'd0, shift}, 64'd0);
        for (int i = 0; i < 15; i++) run_one(dir[i], 1'b0);
        run_one(32'd0, 1'b0);
        run_one(32'd12345, 1'b1);
        run_one(32'd0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            d = $urandom() >> ($urandom() % 32);
            if (d == 0) d = 32'd1;
            run_one(d, (i % 8) == 3);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule